// File: doc/BRIEF.md
# Serial Control Register Receiver for an Audio Processor

This block is a write-only target on a two-wire serial control bus. A host uses it to load the settings of a small audio processor. The block runs on a fast system clock and synchronises both bus lines into that clock domain. It recognises start and stop conditions and shifts bytes in MSB first. It acknowledges on the ninth clock by asserting an open-drain pull-down request.

A transfer follows a fixed order:
1. A START condition.
2. One device address byte, which must equal 0x88.
3. A subaddress byte. It picks a function slot and chooses between single-register writes and auto-incrementing writes.
4. Any number of data bytes.
5. A STOP condition.

Each stored setting is presented already decoded, as a selected source, an input gain in dB, and attenuation values in dB with mute flags. The analog path consumes these values directly.

Top module: `audio_ctl_i2c_rx`

## Requirements
- R1: After reset the block selects source 2 (`src_in1` = 0) and shows a gain of 28 dB. Volume and both speaker channels are muted with their attenuation at 0 dB, and `sda_pull` is 0.
- R2: When the address byte is 0x88, the block asserts `sda_pull` during the ninth clock of that byte and of every later byte in the same transfer, and releases it after that clock's falling edge.
- R3: For any other address byte, `sda_pull` stays 0 and no setting changes until the next START.
- R4: In the subaddress byte, bit 4 enables auto-increment, bits 3..0 give the slot index, and bits 7..5 have no effect.
- R5: With auto-increment off, every data byte until STOP is written to the same slot. The last byte wins. Settings change only when a complete data byte is written.
- R6: With auto-increment on, successive data bytes go to successive indices, wrapping from 15 to 0. Bytes that land on indices 8 to 15 are acknowledged and dropped.
- R7: Slot 0 selects the source. Bits 1..0 = 11 select source 1 (`src_in1` = 1), and 10 selects source 2. Codes 00 and 01 leave the selection unchanged.
- R8: Slot 1 sets the gain to 2 dB times bits 3..0, which gives 0 to 30 dB.
- R9: Slot 2 sets the volume. The coarse field is bits 5..3 and the fine field is bits 2..0. Coarse 0 to 5 gives an attenuation of 8×coarse + fine dB and clears the mute. Coarse 110 or 111 sets the mute and keeps the previous attenuation.
- R10: Slot 6 is the right speaker and slot 7 is the left. The coarse field is bits 6..3 and the fine field is bits 2..0. Coarse 0 to 9 gives 8×coarse + fine dB and clears the mute. Coarse 1111 sets the mute and keeps the attenuation. Coarse 10 to 14 leaves the channel unchanged.
- R11: Writes to slots 3, 4 and 5 change no output.
- R12: A START seen anywhere, including in the middle of a byte, abandons the partial byte and restarts address matching.
- R13: After a STOP, clocked bytes are ignored and not acknowledged until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 requests that the data line be pulled low |
| src_in1 | output | 1 | 1 = source 1, 0 = source 2 |
| gain_db | output | 5 | Input gain in dB |
| vol_db | output | 6 | Volume attenuation in dB |
| vol_mute | output | 1 | Volume mute |
| spk_r_db | output | 7 | Right speaker attenuation in dB |
| spk_r_mute | output | 1 | Right speaker mute |
| spk_l_db | output | 7 | Left speaker attenuation in dB |
| spk_l_mute | output | 1 | Left speaker mute |

## Verification
The assertions assume that the host changes the data line only while the clock line is low, except for deliberate START and STOP conditions. They also assume that each bus level lasts well beyond the synchroniser delay, so both synchronised lines are seen in the order the host drove them.

The stimulus holds each bus phase for several system clocks and moves the data line only in the middle of a clock-low phase. The target's own pull-down is therefore never mistaken for a start or a stop. Repeated STARTs are issued only after the data line has been raised while the clock is low.

// File: rtl/audio_ctl_i2c_rx.sv
module audio_ctl_i2c_rx #(
  parameter logic [7:0] DEV_ADDR  = 8'h88,
  parameter int         SYNC_LEN  = 2,
  parameter logic [3:0] GAIN_RST  = 4'd14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic       src_in1,
  output logic [4:0] gain_db,
  output logic [5:0] vol_db,
  output logic       vol_mute,
  output logic [6:0] spk_r_db,
  output logic       spk_r_mute,
  output logic [6:0] spk_l_db,
  output logic       spk_l_mute
);

  localparam int BITS = 8;
  localparam logic [3:0] LAST_BIT = 4'(BITS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_SKIP} st_t;

  logic [SYNC_LEN-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t        st;
  logic [3:0] bitcnt, idx, wr_idx;
  logic [7:0] shreg, wr_data;
  logic       in_ack, inc, wr_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_LEN-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_LEN-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_LEN-1];
  assign sda_s     = sda_sh[SYNC_LEN-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
      idx      <= '0;
      inc      <= 1'b0;
      wr_pulse <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= 1'b0;
      if (start_det) begin
        st       <= S_ADDR;
        bitcnt   <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        bitcnt   <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && !in_ack && bitcnt != LAST_BIT) begin
          shreg  <= {shreg[BITS-2:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            bitcnt   <= '0;
          end else if (bitcnt == LAST_BIT) begin
            in_ack <= 1'b1;
            case (st)
              S_ADDR: begin
                if (shreg == DEV_ADDR) begin
                  st       <= S_SUB;
                  sda_pull <= 1'b1;
                end else begin
                  st <= S_SKIP;
                end
              end
              S_SUB: begin
                idx      <= shreg[3:0];
                inc      <= shreg[4];
                st       <= S_DATA;
                sda_pull <= 1'b1;
              end
              S_DATA: begin
                sda_pull <= 1'b1;
                wr_pulse <= 1'b1;
                wr_idx   <= idx;
                wr_data  <= shreg;
                if (inc) idx <= idx + 4'd1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_in1    <= 1'b0;
      gain_db    <= {GAIN_RST, 1'b0};
      vol_db     <= '0;
      vol_mute   <= 1'b1;
      spk_r_db   <= '0;
      spk_r_mute <= 1'b1;
      spk_l_db   <= '0;
      spk_l_mute <= 1'b1;
    end else if (wr_pulse) begin
      case (wr_idx)
        4'd0: if (wr_data[1]) src_in1 <= wr_data[0];
        4'd1: gain_db <= {wr_data[3:0], 1'b0};
        4'd2: begin
          if (wr_data[5:4] == 2'b11) vol_mute <= 1'b1;
          else begin
            vol_mute <= 1'b0;
            vol_db   <= wr_data[5:0];
          end
        end
        4'd6: begin
          if (wr_data[6:3] == 4'hF) spk_r_mute <= 1'b1;
          else if (wr_data[6:3] <= 4'd9) begin
            spk_r_mute <= 1'b0;
            spk_r_db   <= wr_data[6:0];
          end
        end
        4'd7: begin
          if (wr_data[6:3] == 4'hF) spk_l_mute <= 1'b1;
          else if (wr_data[6:3] <= 4'd9) begin
            spk_l_mute <= 1'b0;
            spk_l_db   <= wr_data[6:0];
          end
        end
        default: ;
      endcase
    end
  end

  assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_pull);

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable({src_in1, gain_db, vol_db, vol_mute,
                           spk_r_db, spk_r_mute, spk_l_db, spk_l_mute}));

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && inc) |-> (idx == wr_idx + 4'd1));

  assert_vol_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vol_db <= 6'd47);

  assert_spk_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_r_db <= 7'd79) && (spk_l_db <= 7'd79));

  assert_start_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && bitcnt == 4'd0 && !in_ack));

endmodule

// File: tb/audio_ctl_i2c_rx_tb.sv
module audio_ctl_i2c_rx_tb;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_pull, src_in1, vol_mute, spk_r_mute, spk_l_mute;
  logic [4:0] gain_db;
  logic [5:0] vol_db;
  logic [6:0] spk_r_db, spk_l_db;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  audio_ctl_i2c_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .src_in1(src_in1), .gain_db(gain_db),
    .vol_db(vol_db), .vol_mute(vol_mute), .spk_r_db(spk_r_db),
    .spk_r_mute(spk_r_mute), .spk_l_db(spk_l_db), .spk_l_mute(spk_l_mute));

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  bit m_in1 = 0, m_vm = 1, m_srm = 1, m_slm = 1;
  int m_gain = 28, m_vol = 0, m_sr = 0, m_sl = 0;
  int m_idx = 0;
  bit m_inc = 0;
  logic [7:0] q_bytes[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dut_vec();
    return {2'b0, src_in1, gain_db, vol_db, vol_mute, spk_r_db, spk_r_mute,
            spk_l_db, spk_l_mute, sda_pull};
  endfunction

  function automatic logic [31:0] exp_vec();
    return {2'b0, m_in1, 5'(m_gain), 6'(m_vol), m_vm, 7'(m_sr), m_srm,
            7'(m_sl), m_slm, 1'b0};
  endfunction

  always @(negedge clk) if (cmp_en) chk(cur_req, dut_vec(), exp_vec());

  task automatic model_write(int i, logic [7:0] d);
    int c, f;
    f = int'(d[2:0]);
    case (i)
      0: if (d[1]) m_in1 = d[0];
      1: m_gain = 2 * int'(d[3:0]);
      2: begin
        c = int'(d[5:3]);
        if (c >= 6) m_vm = 1;
        else begin m_vm = 0; m_vol = 8 * c + f; end
      end
      6, 7: begin
        c = int'(d[6:3]);
        if (c == 15) begin if (i == 6) m_srm = 1; else m_slm = 1; end
        else if (c <= 9) begin
          if (i == 6) begin m_srm = 0; m_sr = 8 * c + f; end
          else begin m_slm = 0; m_sl = 8 * c + f; end
        end
      end
      default: ;
    endcase
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    cmp_en = 0;
    wq(); sda_m = 1; wq(); scl_m = 1; wq();
    ack = sda_line;
    wq(); scl_m = 0; wq();
  endtask

  // address byte then q_bytes (subaddress first), then STOP
  task automatic xfer(string req, logic [7:0] addr);
    logic ack;
    bit hit;
    hit = (addr == 8'h88);
    cur_req = req;
    bus_start();
    send_byte(addr, ack);
    chk(hit ? "R2" : "R3", {31'b0, ack}, {31'b0, !hit});
    cmp_en = 1;
    for (int k = 0; k < q_bytes.size(); k++) begin
      send_byte(q_bytes[k], ack);
      chk(hit ? "R2" : "R3", {31'b0, ack}, {31'b0, !hit});
      if (hit) begin
        if (k == 0) begin m_idx = int'(q_bytes[k][3:0]); m_inc = q_bytes[k][4]; end
        else begin
          model_write(m_idx, q_bytes[k]);
          if (m_inc) m_idx = (m_idx + 1) % 16;
        end
      end
      cmp_en = 1;
    end
    bus_stop();
    q_bytes.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", dut_vec(), {2'b0, 1'b0, 5'd28, 6'd0, 1'b1, 7'd0, 1'b1, 7'd0, 1'b1, 1'b0});
    cmp_en = 1;

    // R4 R8: ignored upper bits, gain slot, single write
    q_bytes = '{8'hE1, 8'h05}; xfer("R4", 8'h88);
    chk("R8", {27'b0, gain_db}, 32'd10);

    // R5: fixed slot, last byte wins
    q_bytes = '{8'h02, 8'h09, 8'h2B}; xfer("R5", 8'h88);
    chk("R5", {26'b0, vol_db}, 32'd43);

    // R9: mute keeps attenuation, then unmute
    q_bytes = '{8'h02, 8'h30}; xfer("R9", 8'h88);
    chk("R9", {25'b0, vol_mute, vol_db}, {25'b0, 1'b1, 6'd43});
    q_bytes = '{8'h02, 8'h07}; xfer("R9", 8'h88);
    chk("R9", {25'b0, vol_mute, vol_db}, {25'b0, 1'b0, 6'd7});

    // R7: source select with illegal codes
    q_bytes = '{8'h00, 8'h03, 8'h01}; xfer("R7", 8'h88);
    chk("R7", {31'b0, src_in1}, 32'd1);
    q_bytes = '{8'h00, 8'h02, 8'hFC}; xfer("R7", 8'h88);
    chk("R7", {31'b0, src_in1}, 32'd0);

    // R10: right then left via increment, mute, unlisted codes
    q_bytes = '{8'h16, 8'h4D, 8'h11}; xfer("R10", 8'h88);
    chk("R10", {24'b0, spk_r_db, spk_r_mute}, {24'b0, 7'd77, 1'b0});
    chk("R10", {24'b0, spk_l_db, spk_l_mute}, {24'b0, 7'd17, 1'b0});
    q_bytes = '{8'h06, 8'h78, 8'h50}; xfer("R10", 8'h88);
    chk("R10", {24'b0, spk_r_db, spk_r_mute}, {24'b0, 7'd77, 1'b1});
    q_bytes = '{8'h07, 8'h5F}; xfer("R10", 8'h88);
    chk("R10", {24'b0, spk_l_db, spk_l_mute}, {24'b0, 7'd17, 1'b0});

    // R6: increment through dropped indices and wrap 15 -> 0
    q_bytes = '{8'h1E, 8'h0F, 8'h0F, 8'h03, 8'h0F}; xfer("R6", 8'h88);
    chk("R6", {26'b0, src_in1, gain_db}, {26'b0, 1'b1, 5'd30});
    q_bytes = '{8'h15, 8'h00, 8'h20, 8'h08, 8'h00, 8'h00}; xfer("R6", 8'h88);
    chk("R6", {16'b0, spk_r_db, spk_r_mute, spk_l_db, spk_l_mute},
        {16'b0, 7'd32, 1'b0, 7'd8, 1'b0});

    // R11: unused slots
    q_bytes = '{8'h03, 8'hFF, 8'h00}; xfer("R11", 8'h88);
    q_bytes = '{8'h14, 8'h12, 8'h34}; xfer("R11", 8'h88);
    chk("R11", {26'b0, gain_db, src_in1}, {26'b0, 5'd30, 1'b1});

    // R3: other address bytes
    q_bytes = '{8'h01, 8'h00}; xfer("R3", 8'h8A);
    q_bytes = '{8'h01, 8'h00}; xfer("R3", 8'h89);
    chk("R3", {27'b0, gain_db}, 32'd30);

    // R12: START mid subaddress, mid data, and after a mismatch
    cur_req = "R12";
    bus_start();
    send_byte(8'h88, ack); chk("R12", {31'b0, ack}, 32'd0); cmp_en = 1;
    send_bits(8'h01, 5);
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    send_byte(8'h88, ack); chk("R12", {31'b0, ack}, 32'd0); cmp_en = 1;
    send_byte(8'h01, ack); cmp_en = 1;
    send_byte(8'h04, ack); m_gain = 8; cmp_en = 1;
    send_bits(8'h0F, 6);
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    send_byte(8'h90, ack); chk("R12", {31'b0, ack}, 32'd1); cmp_en = 1;
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
    send_byte(8'h88, ack); chk("R12", {31'b0, ack}, 32'd0); cmp_en = 1;
    bus_stop();
    chk("R12", {27'b0, gain_db}, 32'd8);

    // R13: bytes after STOP without START
    cur_req = "R13";
    scl_m = 0; wq();
    send_byte(8'h88, ack); chk("R13", {31'b0, ack}, 32'd1); cmp_en = 1;
    send_byte(8'h01, ack); chk("R13", {31'b0, ack}, 32'd1); cmp_en = 1;
    send_byte(8'h00, ack); cmp_en = 1;
    wq(); scl_m = 1; wq(); wq();
    chk("R13", {27'b0, gain_db}, 32'd8);

    cmp_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule